// File: doc/BRIEF.md
# Shifted-Address Post-Update Load Unit

This block executes a family of 64-bit indexed loads that also update their base register. Each load reads memory at an address formed by shifting the base operand left by one to eight bit positions. After the access, the base register is written with the sum of the base and index operands. The block receives an already decoded operation with these fields:

- access size: byte, halfword, word or doubleword;
- a sign-extension flag;
- the target and base register numbers;
- the base and index operand values;
- a 3-bit shift field.

The block issues a single read request on a valid/ready memory port and waits for the response. It then presents two write-back results in the same cycle: the formatted load value for the target register, and the updated base value for the base register.

An instruction form is illegal when its base register is register 0 or is the same as its target register. The block raises a one-cycle invalid flag for it, makes no memory request and performs no write-back. The block changes no status or special register. A new operation is taken only while the unit is idle.

Top module: `shload_unit`

## Requirements
- R1: When an operation is accepted, `mem_req_addr` equals `ra_val` shifted left by `sh_amt`+1. Bits shifted beyond bit 63 are dropped, and `rb_val` has no effect on the address.
- R2: `mem_req_bytes` is 1, 2, 4 or 8 for `op_size` codes 0 (byte), 1 (halfword), 2 (word) and 3 (doubleword).
- R3: A byte load writes the byte into bits 7:0 of `rt_wb_data` and zeroes bits 63:8. `op_signed` has no effect on a byte load.
- R4: A halfword load places 16 bits in bits 15:0. Bits 63:16 are zero when `op_signed`=0, and copies of bit 15 when `op_signed`=1.
- R5: A word load places 32 bits in bits 31:0. Bits 63:32 are zero when `op_signed`=0, and copies of bit 31 when `op_signed`=1.
- R6: A doubleword load returns all 64 response bits unchanged. `op_signed` has no effect on it.
- R7: On write-back, `ra_wb_data` is the accepted `ra_val`+`rb_val` modulo 2^64. `rt_wb_idx` and `ra_wb_idx` carry the accepted `rt_idx` and `ra_idx`.
- R8: `rt_wb_valid` and `ra_wb_valid` rise together in the cycle after the response is taken. They stay high for exactly one cycle.
- R9: If `ra_idx`=0 or `ra_idx`=`rt_idx` when an operation is presented in idle, `invalid_form` is high for the next cycle only. No request or write-back follows, and `issue_ready` stays high.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address and size stay unchanged. Exactly one request is made per valid operation.
- R11: `issue_ready` is high only in idle. While the unit is busy, `issue_valid` is ignored and the operation in progress completes unchanged.
- R12: Synchronous active-high `rst` returns the unit to idle. In idle `issue_ready`=1, and all valid outputs and `invalid_form` are 0.
- R13: The loaded quantity is taken from the low 8×size bits of `mem_rsp_data`, and any higher response bits are ignored. Memory supplies the quantity big-endian: the byte at the lowest address is its most-significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation presented |
| issue_ready | output | 1 | Unit idle and able to accept |
| op_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| op_signed | input | 1 | Sign-extend the loaded value (half and word only) |
| rt_idx | input | 5 | Target register number |
| ra_idx | input | 5 | Base register number |
| ra_val | input | 64 | Base operand value |
| rb_val | input | 64 | Index operand value |
| sh_amt | input | 3 | Shift field; the address shift is this value plus 1 |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read address |
| mem_req_bytes | output | 4 | Read size in bytes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-justified, big-endian |
| rt_wb_valid | output | 1 | Target write-back valid |
| rt_wb_idx | output | 5 | Target write-back register |
| rt_wb_data | output | 64 | Formatted load value |
| ra_wb_valid | output | 1 | Base write-back valid |
| ra_wb_idx | output | 5 | Base write-back register |
| ra_wb_data | output | 64 | Updated base value |
| invalid_form | output | 1 | One-cycle illegal-form flag |

## Verification
The hardest condition to reach from the ports is an operation arriving while the unit is busy. It has to land in the waiting phase with fields that differ from the operation in progress, and it must be dropped before the unit returns to idle. The stimulus raises `issue_valid` with unrelated fields during the response wait, and releases it in the same cycle the response is given. Some random operations also hold the request under backpressure for several cycles. Directed cases cover a shift of 8 with high base bits set, sign bits set and clear, and a base plus index sum that wraps.

// File: rtl/shload_pkg.sv
package shload_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} ld_size_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2, ST_WB = 2'd3} ld_state_e;
endpackage

// File: rtl/shload_addr.sv
module shload_addr #(
  parameter int XLEN = 64,
  parameter int SHW  = 3
) (
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  input  logic [SHW-1:0]  sh_field,
  output logic [XLEN-1:0] eff_addr,
  output logic [XLEN-1:0] base_next
);
  function automatic logic [XLEN-1:0] shifted_addr(input logic [XLEN-1:0] b, input logic [SHW-1:0] s);
    int amt;
    amt = int'(s) + 1;
    return b << amt;
  endfunction

  function automatic logic [XLEN-1:0] post_sum(input logic [XLEN-1:0] b, input logic [XLEN-1:0] x);
    return b + x;
  endfunction

  assign eff_addr  = shifted_addr(base_val, sh_field);
  assign base_next = post_sum(base_val, index_val);
endmodule

// File: rtl/shload_fmt.sv
module shload_fmt
  import shload_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  ld_size_e        size,
  input  logic            sext,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] value
);
  function automatic logic [XLEN-1:0] format_load(input ld_size_e sz, input logic sg, input logic [XLEN-1:0] d);
    logic [XLEN-1:0] v;
    case (sz)
      SZ_B:    v = {{(XLEN-8){1'b0}}, d[7:0]};
      SZ_H:    v = {{(XLEN-16){sg & d[15]}}, d[15:0]};
      SZ_W:    v = {{(XLEN-32){sg & d[31]}}, d[31:0]};
      default: v = d;
    endcase
    return v;
  endfunction

  assign value = format_load(size, sext, raw);
endmodule

// File: rtl/shload_ctrl.sv
module shload_ctrl
  import shload_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      issue_valid,
  input  logic      form_bad,
  input  logic      req_ready,
  input  logic      rsp_valid,
  output ld_state_e state,
  output logic      accept_ok,
  output logic      accept_bad,
  output logic      req_fire,
  output logic      rsp_fire
);
  ld_state_e state_n;

  assign accept_ok  = (state == ST_IDLE) & issue_valid & ~form_bad;
  assign accept_bad = (state == ST_IDLE) & issue_valid & form_bad;
  assign req_fire   = (state == ST_REQ) & req_ready;
  assign rsp_fire   = (state == ST_WAIT) & rsp_valid;

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE: if (accept_ok) state_n = ST_REQ;
      ST_REQ:  if (req_fire)  state_n = ST_WAIT;
      ST_WAIT: if (rsp_fire)  state_n = ST_WB;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_n;
  end
endmodule

// File: rtl/shload_unit.sv
module shload_unit
  import shload_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int SHW  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       issue_valid,
  output logic                       issue_ready,
  input  logic [1:0]                 op_size,
  input  logic                       op_signed,
  input  logic [REGW-1:0]            rt_idx,
  input  logic [REGW-1:0]            ra_idx,
  input  logic [XLEN-1:0]            ra_val,
  input  logic [XLEN-1:0]            rb_val,
  input  logic [SHW-1:0]             sh_amt,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [XLEN-1:0]            mem_req_addr,
  output logic [$clog2(XLEN/8):0]    mem_req_bytes,
  input  logic                       mem_rsp_valid,
  input  logic [XLEN-1:0]            mem_rsp_data,
  output logic                       rt_wb_valid,
  output logic [REGW-1:0]            rt_wb_idx,
  output logic [XLEN-1:0]            rt_wb_data,
  output logic                       ra_wb_valid,
  output logic [REGW-1:0]            ra_wb_idx,
  output logic [XLEN-1:0]            ra_wb_data,
  output logic                       invalid_form
);
  localparam int BYTESW = $clog2(XLEN/8) + 1;

  ld_state_e       state;
  logic            accept_ok, accept_bad, req_fire, rsp_fire;
  logic            form_bad;
  logic [XLEN-1:0] ea_c, upd_c, fmt_c;
  logic [XLEN-1:0] ea_q, upd_q, load_q;
  ld_size_e        cur_size;
  logic            sgn_q, bad_q;
  logic [REGW-1:0] rt_q, ra_q;

  assign form_bad = (ra_idx == '0) | (ra_idx == rt_idx);

  shload_ctrl u_ctrl (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .form_bad(form_bad),
    .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid), .state(state),
    .accept_ok(accept_ok), .accept_bad(accept_bad), .req_fire(req_fire), .rsp_fire(rsp_fire)
  );

  shload_addr #(.XLEN(XLEN), .SHW(SHW)) u_addr (
    .base_val(ra_val), .index_val(rb_val), .sh_field(sh_amt),
    .eff_addr(ea_c), .base_next(upd_c)
  );

  shload_fmt #(.XLEN(XLEN)) u_fmt (
    .size(cur_size), .sext(sgn_q), .raw(mem_rsp_data), .value(fmt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_q     <= '0;
      upd_q    <= '0;
      cur_size <= SZ_B;
      sgn_q    <= 1'b0;
      rt_q     <= '0;
      ra_q     <= '0;
    end else if (accept_ok) begin
      ea_q     <= ea_c;
      upd_q    <= upd_c;
      cur_size <= ld_size_e'(op_size);
      sgn_q    <= op_signed;
      rt_q     <= rt_idx;
      ra_q     <= ra_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           load_q <= '0;
    else if (rsp_fire) load_q <= fmt_c;
  end

  always_ff @(posedge clk) begin
    if (rst) bad_q <= 1'b0;
    else     bad_q <= accept_bad;
  end

  assign issue_ready   = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign mem_req_bytes = BYTESW'(1) << cur_size;
  assign rt_wb_valid   = (state == ST_WB);
  assign ra_wb_valid   = (state == ST_WB);
  assign rt_wb_idx     = rt_q;
  assign ra_wb_idx     = ra_q;
  assign rt_wb_data    = load_q;
  assign ra_wb_data    = upd_q;
  assign invalid_form  = bad_q;
endmodule

// File: rtl/shload_unit_chk.sv
module shload_unit_chk #(
  parameter int XLEN = 64,
  parameter int BYTESW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [XLEN-1:0]   mem_req_addr,
  input logic [BYTESW-1:0] mem_req_bytes,
  input logic              rt_wb_valid,
  input logic              ra_wb_valid,
  input logic [XLEN-1:0]   rt_wb_data,
  input logic              invalid_form,
  input logic [1:0]        cur_size
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_bytes));

  p_single_req_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  p_wb_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (rt_wb_valid || ra_wb_valid) |-> (rt_wb_valid && ra_wb_valid));

  p_wb_once_r8: assert property (@(posedge clk) disable iff (rst)
    rt_wb_valid |=> !rt_wb_valid);

  p_bad_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    invalid_form |-> !mem_req_valid && !rt_wb_valid && !ra_wb_valid && issue_ready);

  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || rt_wb_valid) |-> !issue_ready);

  p_byte_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rt_wb_valid && cur_size == 2'd0 |-> rt_wb_data[XLEN-1:8] == '0);

  p_size_code_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> $onehot0(mem_req_bytes) && mem_req_bytes != '0);
endmodule

bind shload_unit shload_unit_chk #(.XLEN(XLEN), .BYTESW(BYTESW)) u_chk (
  .clk(clk), .rst(rst), .issue_ready(issue_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_bytes(mem_req_bytes),
  .rt_wb_valid(rt_wb_valid), .ra_wb_valid(ra_wb_valid), .rt_wb_data(rt_wb_data),
  .invalid_form(invalid_form), .cur_size(cur_size)
);

// File: tb/shload_unit_tb.sv
module shload_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [1:0]  op_size = '0;
  logic        op_signed = 1'b0;
  logic [4:0]  rt_idx = '0, ra_idx = '0;
  logic [63:0] ra_val = '0, rb_val = '0;
  logic [2:0]  sh_amt = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [3:0]  mem_req_bytes;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rt_wb_valid, ra_wb_valid, invalid_form;
  logic [4:0]  rt_wb_idx, ra_wb_idx;
  logic [63:0] rt_wb_data, ra_wb_data;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  shload_unit u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .op_size(op_size), .op_signed(op_signed), .rt_idx(rt_idx), .ra_idx(ra_idx),
    .ra_val(ra_val), .rb_val(rb_val), .sh_amt(sh_amt),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_bytes(mem_req_bytes),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rt_wb_valid(rt_wb_valid), .rt_wb_idx(rt_wb_idx), .rt_wb_data(rt_wb_data),
    .ra_wb_valid(ra_wb_valid), .ra_wb_idx(ra_wb_idx), .ra_wb_data(ra_wb_data),
    .invalid_form(invalid_form)
  );

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=150000", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench memory contents: one byte per address
  function automatic logic [7:0] mem_byte(input logic [63:0] a);
    logic [63:0] h;
    h = a * 64'h9E3779B97F4A7C15;
    return h[63:56] ^ a[7:0];
  endfunction

  function automatic logic [63:0] exp_load(input logic [1:0] sz, input logic sg, input logic [63:0] q);
    logic [63:0] r;
    case (sz)
      2'd0: r = q & 64'hFF;
      2'd1: r = (sg && q[15]) ? (q | ~64'hFFFF) : (q & 64'hFFFF);
      2'd2: r = (sg && q[31]) ? (q | ~64'hFFFF_FFFF) : (q & 64'hFFFF_FFFF);
      default: r = q;
    endcase
    return r;
  endfunction

  task automatic run_op(input logic [1:0] sz, input logic sg, input logic [4:0] rt, input logic [4:0] ra,
                        input logic [63:0] a, input logic [63:0] b, input logic [2:0] sh,
                        input int rq_dly, input int rsp_dly, input bit poke);
    logic [63:0] ea_e, q, rsp, exp_rt;
    int n;
    string tag;
    n = 1 << sz;
    ea_e = a * (64'd1 << (int'(sh) + 1));
    q = '0;
    for (int i = 0; i < n; i++) q = (q << 8) | {56'd0, mem_byte(ea_e + 64'(i))};
    rsp = (n == 8) ? q : (({$urandom, $urandom} << (8 * n)) | q);
    exp_rt = exp_load(sz, sg, q);
    case (sz)
      2'd0: tag = "R3 R13";
      2'd1: tag = "R4 R13";
      2'd2: tag = "R5 R13";
      default: tag = "R6 R13";
    endcase
    @(negedge clk);
    issue_valid = 1'b1; op_size = sz; op_signed = sg; rt_idx = rt; ra_idx = ra;
    ra_val = a; rb_val = b; sh_amt = sh;
    @(negedge clk);
    issue_valid = 1'b0; ra_val = {$urandom, $urandom}; rb_val = {$urandom, $urandom};
    chk(!issue_ready, "R11 busy", 64'(issue_ready), 64'd0);
    chk(mem_req_valid && mem_req_addr == ea_e, "R1 addr", mem_req_addr, ea_e);
    chk(mem_req_bytes == 4'(n), "R2 size", 64'(mem_req_bytes), 64'(n));
    for (int k = 0; k < rq_dly; k++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == ea_e, "R10 hold", mem_req_addr, ea_e);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(!mem_req_valid, "R10 one request", 64'(mem_req_valid), 64'd0);
    for (int k = 0; k < rsp_dly; k++) begin
      if (poke && k == 0) begin
        issue_valid = 1'b1; op_size = ~sz; op_signed = ~sg; rt_idx = 5'd3; ra_idx = 5'd4;
        ra_val = {$urandom, $urandom}; sh_amt = ~sh;
      end
      @(negedge clk);
      chk(!rt_wb_valid && !mem_req_valid, "R11 ignored while busy", 64'(rt_wb_valid), 64'd0);
    end
    issue_valid = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = rsp;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = {$urandom, $urandom};
    chk(rt_wb_valid && ra_wb_valid, "R8 wb valid", {62'd0, rt_wb_valid, ra_wb_valid}, 64'd3);
    chk(rt_wb_data == exp_rt, tag, rt_wb_data, exp_rt);
    chk(ra_wb_data == a + b, "R7 update", ra_wb_data, a + b);
    chk(rt_wb_idx == rt && ra_wb_idx == ra, "R7 idx", {54'd0, rt_wb_idx, ra_wb_idx}, {54'd0, rt, ra});
    @(negedge clk);
    chk(!rt_wb_valid && !ra_wb_valid, "R8 one cycle", {62'd0, rt_wb_valid, ra_wb_valid}, 64'd0);
    chk(issue_ready, "R11 idle", 64'(issue_ready), 64'd1);
  endtask

  task automatic run_bad(input logic [4:0] rt, input logic [4:0] ra);
    @(negedge clk);
    issue_valid = 1'b1; rt_idx = rt; ra_idx = ra; ra_val = {$urandom, $urandom};
    op_size = 2'($urandom); sh_amt = 3'($urandom);
    @(negedge clk);
    issue_valid = 1'b0;
    chk(invalid_form, "R9 flag", 64'(invalid_form), 64'd1);
    chk(!mem_req_valid && !rt_wb_valid && !ra_wb_valid && issue_ready, "R9 quiet",
        {60'd0, mem_req_valid, rt_wb_valid, ra_wb_valid, issue_ready}, 64'd1);
    @(negedge clk);
    chk(!invalid_form && !mem_req_valid, "R9 one cycle", {62'd0, invalid_form, mem_req_valid}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(issue_ready && !mem_req_valid && !rt_wb_valid && !ra_wb_valid && !invalid_form, "R12 reset",
        {59'd0, issue_ready, mem_req_valid, rt_wb_valid, ra_wb_valid, invalid_form}, 64'h10);

    // directed corners
    run_op(2'd3, 1'b1, 5'd1, 5'd2, 64'hF000_0000_0000_0013, 64'd5, 3'd7, 0, 0, 1'b0); // R1 overflow dropped, R6
    run_op(2'd0, 1'b1, 5'd7, 5'd9, 64'h0000_0000_0000_1234, 64'd1, 3'd0, 2, 1, 1'b0); // R3 sign ignored
    run_op(2'd1, 1'b1, 5'd2, 5'd31, 64'h0000_0000_0000_4001, 64'd2, 3'd1, 0, 0, 1'b0); // R4
    run_op(2'd1, 1'b0, 5'd2, 5'd31, 64'h0000_0000_0000_4001, 64'd2, 3'd1, 0, 0, 1'b0); // R4
    run_op(2'd2, 1'b1, 5'd5, 5'd6, 64'h0000_0000_0ABC_0001, 64'd0, 3'd2, 1, 3, 1'b1); // R5, R11
    run_op(2'd2, 1'b0, 5'd5, 5'd6, 64'h0000_0000_0ABC_0001, 64'd0, 3'd2, 0, 0, 1'b0); // R5
    run_op(2'd3, 1'b0, 5'd8, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 3'd3, 4, 2, 1'b1); // R7 wrap
    run_bad(5'd4, 5'd0);
    run_bad(5'd9, 5'd9);
    run_bad(5'd0, 5'd0);

    // reset in the middle of an operation
    @(negedge clk);
    issue_valid = 1'b1; ra_idx = 5'd3; rt_idx = 5'd4; ra_val = 64'd7; op_size = 2'd1;
    @(negedge clk);
    issue_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(issue_ready && !mem_req_valid && !rt_wb_valid && !invalid_form, "R12 mid reset",
        {60'd0, issue_ready, mem_req_valid, rt_wb_valid, invalid_form}, 64'h8);

    // constrained random
    for (int t = 0; t < 400; t++) begin
      logic [4:0] ra_r, rt_r;
      if ($urandom_range(9) == 0) begin
        ra_r = ($urandom_range(1) == 0) ? 5'd0 : 5'($urandom_range(31, 1));
        rt_r = (ra_r == 5'd0) ? 5'($urandom) : ra_r;
        run_bad(rt_r, ra_r);
      end else begin
        ra_r = 5'($urandom_range(31, 1));
        rt_r = 5'($urandom);
        if (rt_r == ra_r) rt_r = ra_r + 5'd1;
        run_op(2'($urandom), 1'($urandom), rt_r, ra_r, {$urandom, $urandom}, {$urandom, $urandom},
               3'($urandom), $urandom_range(3), $urandom_range(3) + 1, 1'($urandom_range(1)));
      end
    end

    report();
    $finish;
  end
endmodule